// File: doc/BRIEF.md
# Per-Hart Software Interrupt Generator

This block lets software running on any hart raise a software (inter-processor) interrupt toward one of up to eight harts by writing a 32-bit word at a per-hart offset. Each hart owns one word-aligned register at byte offset 4 × n. Only bit 0 of the written data carries meaning.

A build-time parameter picks one of two flavours. In the level flavour (`SUPERVISOR = 0`), every hart has a stored pending bit. A write of 1 sets it and a write of 0 clears it, the bit drives a held interrupt level, and reads return it. In the pulse flavour (`SUPERVISOR = 1`), a write of 1 only emits a one-cycle set request toward the hart, which latches it on its own side. A write of 0 does nothing, and reads always return zero.

Each hart is handled by a two-state machine. The states are `HS_IDLE` (output low) and `HS_RAISED` (output high). The transitions are:

- SET: `HS_IDLE` to `HS_RAISED` on a write of 1.
- CLEAR: `HS_RAISED` to `HS_IDLE`. In the level flavour this happens on a write of 0. In the pulse flavour it happens on any cycle without a new write of 1.
- RESET: any state to `HS_IDLE`.

Top module: `swi_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, all `irq_o` bits, `rsp_valid` and `rsp_rdata` are zero.
- R2: A request is accepted only when `req_size` is 2 (word; 0 = byte, 1 = half, 3 = double) and `req_addr[1:0]` is 0. An accepted request addresses hart `req_addr >> 2`, which must be below `NUM_HARTS`. It affects that hart alone.
- R3: In the level flavour, an accepted write with `req_wdata[0]` = 1 sets the hart's `irq_o` bit from the next cycle on. The bit then stays high until it is cleared or reset.
- R4: In the level flavour, an accepted write with `req_wdata[0]` = 0 clears the hart's `irq_o` bit from the next cycle on. Bits 31..1 of the write data have no effect.
- R5: Every request cycle is followed one cycle later by `rsp_valid` high. In the level flavour, an accepted read returns the hart's pending bit in `rsp_rdata[0]`, with bits 31..1 zero.
- R6: In the pulse flavour, an accepted write of 1 drives the hart's `irq_o` bit high for exactly the next cycle. The bit stays high only if further writes of 1 arrive back to back.
- R7: In the pulse flavour, a write of 0 changes no output, and every read returns zero.
- R8: A request with a wrong size, a misaligned address or an out-of-range hart index changes no `irq_o` bit. If it is a read, it returns zero.
- R9: A read never changes any `irq_o` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code; only 2 (word) is accepted |
| req_addr | input | ADDR_W | Byte offset inside the block |
| req_wdata | input | 32 | Write data; only bit 0 is used |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, zero for writes and rejected accesses |
| irq_o | output | NUM_HARTS | Per-hart interrupt level (level flavour) or set pulse (pulse flavour) |

## Verification
A hart machine left stuck in `HS_RAISED` appears at `irq_o` one cycle after the write that should have cleared it. In the pulse flavour it appears one cycle after the pulse should have ended. A wrong decode shows as a neighbouring hart's bit moving, or as a rejected access leaving a trace, in the cycle right after the request. Read-back errors surface in `rsp_rdata` one cycle after the read. The bench drives both flavours with the same stimulus and compares every output to a behavioural model on every clock, so any such divergence is seen within one cycle.

// File: rtl/swi_pkg.sv
package swi_pkg;
    typedef enum logic {
        HS_IDLE   = 1'b0,
        HS_RAISED = 1'b1
    } hart_state_e;

    localparam logic [1:0] SZ_WORD    = 2'd2;
    localparam int unsigned BUS_W     = 32;
    localparam int unsigned MAX_HARTS = 8;
endpackage

// File: rtl/swi_addr_decode.sv
module swi_addr_decode #(
    parameter int unsigned NUM_HARTS = 4,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [1:0]           req_size,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 hit,
    output logic [NUM_HARTS-1:0] wr_sel,
    output logic [NUM_HARTS-1:0] rd_sel
);
    import swi_pkg::*;

    localparam int unsigned IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] HART_LIMIT = IDX_W'(NUM_HARTS);

    logic [IDX_W-1:0] word_idx;

    always_comb begin
        word_idx = req_addr[ADDR_W-1:2];
        hit = req_valid && (req_size == SZ_WORD) &&
              (req_addr[1:0] == 2'b00) && (word_idx < HART_LIMIT);
    end

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_sel
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(h);
        always_comb begin
            wr_sel[h] = hit && req_write  && (word_idx == MY_IDX);
            rd_sel[h] = hit && !req_write && (word_idx == MY_IDX);
        end
    end

    // R2: at most one hart addressed per request
    p_onehot_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel | rd_sel));
    // R8: rejected access selects nobody
    p_reject_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> ((wr_sel | rd_sel) == '0));
endmodule

// File: rtl/swi_hart_cell.sv
module swi_hart_cell #(
    parameter bit SUPERVISOR = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    output logic irq_o,
    output logic pend_o
);
    import swi_pkg::*;

    hart_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    generate
        if (SUPERVISOR) begin : g_pulse
            always_comb begin
                state_d = state_q;
                unique case (state_q)
                    HS_IDLE:   if (wr_en && wr_bit)    state_d = HS_RAISED;
                    HS_RAISED: if (!(wr_en && wr_bit)) state_d = HS_IDLE;
                    default:                           state_d = HS_IDLE;
                endcase
            end
        end else begin : g_level
            always_comb begin
                state_d = state_q;
                unique case (state_q)
                    HS_IDLE:   if (wr_en && wr_bit)  state_d = HS_RAISED;
                    HS_RAISED: if (wr_en && !wr_bit) state_d = HS_IDLE;
                    default:                         state_d = HS_IDLE;
                endcase
            end
        end
    endgenerate

    always_comb begin
        irq_o  = (state_q == HS_RAISED);
        pend_o = SUPERVISOR ? 1'b0 : (state_q == HS_RAISED);
    end

    // R3 / R6: a write of 1 raises the output next cycle
    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bit) |=> irq_o);

    generate
        if (SUPERVISOR) begin : g_pulse_chk
            // R6: the pulse lasts one cycle unless renewed
            p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && wr_bit) |=> !irq_o);
        end else begin : g_level_chk
            // R4: a write of 0 clears the level
            p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && !wr_bit) |=> !irq_o);
            // R9: without a write the level holds
            p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_en |=> $stable(irq_o));
        end
    endgenerate
endmodule

// File: rtl/swi_unit.sv
module swi_unit #(
    parameter int unsigned NUM_HARTS  = 4,
    parameter bit          SUPERVISOR = 1'b0,
    parameter int unsigned ADDR_W     = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [1:0]           req_size,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_rdata,
    output logic [NUM_HARTS-1:0] irq_o
);
    import swi_pkg::*;

    logic                 hit;
    logic [NUM_HARTS-1:0] wr_sel;
    logic [NUM_HARTS-1:0] rd_sel;
    logic [NUM_HARTS-1:0] pend_vec;
    logic                 rd_bit;

    swi_addr_decode #(
        .NUM_HARTS (NUM_HARTS),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .hit       (hit),
        .wr_sel    (wr_sel),
        .rd_sel    (rd_sel)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        swi_hart_cell #(
            .SUPERVISOR (SUPERVISOR)
        ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_sel[h]),
            .wr_bit (req_wdata[0]),
            .irq_o  (irq_o[h]),
            .pend_o (pend_vec[h])
        );
    end

    always_comb rd_bit = |(rd_sel & pend_vec);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= {{(BUS_W-1){1'b0}}, rd_bit};
        end
    end

    // R5: each request is answered on the following cycle
    p_resp_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_rdata == '0));
    // R8: rejected accesses read zero
    p_reject_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit) |=> (rsp_rdata == '0));
    // R9: reads leave every output alone
    p_read_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !SUPERVISOR) |=> $stable(irq_o));
endmodule

// File: tb/swi_unit_tb.sv
module swi_unit_tb;
    localparam int NH = 4;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;

    logic          rv_m, rv_s;
    logic [31:0]   rd_m, rd_s;
    logic [NH-1:0] irq_m, irq_s;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    string cur_tag = "R1";

    logic [NH-1:0] m_pend;
    logic [NH-1:0] s_pulse;
    logic          e_rv;
    logic [31:0]   e_rd_m;

    always #5 clk = ~clk;

    swi_unit #(.NUM_HARTS(NH), .SUPERVISOR(1'b0), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rv_m), .rsp_rdata(rd_m), .irq_o(irq_m));

    swi_unit #(.NUM_HARTS(NH), .SUPERVISOR(1'b1), .ADDR_W(AW)) u_dut_sup (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rv_s), .rsp_rdata(rd_s), .irq_o(irq_s));

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend  = '0;
            s_pulse = '0;
            e_rv    = 1'b0;
            e_rd_m  = '0;
        end else begin
            int idx;
            bit ok;
            idx = int'(req_addr) / 4;
            ok = req_valid && (req_size == 2'd2) && (req_addr[1:0] == 2'b00) && (idx < NH);
            e_rv = req_valid;
            e_rd_m = (ok && !req_write) ? {31'd0, m_pend[idx]} : 32'd0;
            s_pulse = '0;
            if (ok && req_write) begin
                m_pend[idx] = req_wdata[0];
                if (req_wdata[0]) s_pulse[idx] = 1'b1;
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("irq level", 32'(irq_m), 32'(m_pend));
        chk("irq pulse", 32'(irq_s), 32'(s_pulse));
        chk("rsp_valid level", 32'(rv_m), 32'(e_rv));
        chk("rsp_valid pulse", 32'(rv_s), 32'(e_rv));
        chk("rdata level", rd_m, e_rd_m);
        chk("rdata pulse", rd_s, 32'd0);
    endtask

    task automatic step(input bit v, input bit w, input logic [1:0] sz,
                        input logic [AW-1:0] a, input logic [31:0] d, input string tag);
        @(negedge clk);
        compare();
        req_valid = v; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
        cur_tag = tag;
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 2'd0, '0, 32'd0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset state");
        idle("R1 reset state");
        // R3: set hart 0, level holds
        step(1, 1, 2'd2, 12'h000, 32'h1, "R3 set hart0");
        idle("R3 hold");
        idle("R3 hold");
        // R2: offset 4*n reaches hart n
        step(1, 1, 2'd2, 12'h00C, 32'h1, "R2 set hart3");
        // R6: back-to-back pulses
        step(1, 1, 2'd2, 12'h004, 32'h1, "R6 pulse hart1");
        step(1, 1, 2'd2, 12'h004, 32'h1, "R6 pulse hart1 again");
        idle("R6 pulse end");
        // R5 / R9: reads
        step(1, 0, 2'd2, 12'h00C, 32'h0, "R5 read hart3");
        step(1, 0, 2'd2, 12'h008, 32'h0, "R5 read hart2");
        step(1, 0, 2'd2, 12'h000, 32'h0, "R9 read hart0");
        idle("R9 after read");
        // R4: only bit 0 counts
        step(1, 1, 2'd2, 12'h000, 32'hFFFF_FFFE, "R4 clear hart0");
        step(1, 1, 2'd2, 12'h008, 32'h0000_0002, "R4 bit1 ignored");
        step(1, 0, 2'd2, 12'h008, 32'h0, "R4 read hart2");
        // R7: write 0 in pulse flavour does nothing
        step(1, 1, 2'd2, 12'h004, 32'h0, "R7 write zero");
        idle("R7 quiet");
        // R8: rejected requests
        step(1, 1, 2'd2, 12'h006, 32'h1, "R8 misaligned write");
        step(1, 1, 2'd2, 12'h010, 32'h1, "R8 out of range write");
        step(1, 1, 2'd0, 12'h008, 32'h1, "R8 byte write");
        step(1, 1, 2'd3, 12'h008, 32'h1, "R8 double write");
        step(1, 0, 2'd1, 12'h00C, 32'h0, "R8 half read");
        step(1, 0, 2'd2, 12'h00D, 32'h0, "R8 misaligned read");
        step(1, 0, 2'd2, 12'h3FC, 32'h0, "R8 far read");
        idle("R8 quiet");
        // multi-hart pattern
        for (int h = 0; h < NH; h++) step(1, 1, 2'd2, AW'(4 * h), 32'(h % 2), "R2 pattern");
        for (int h = 0; h < NH; h++) step(1, 0, 2'd2, AW'(4 * h), 32'h0, "R5 pattern read");
        idle("R5 pattern end");
        // R1: reset mid-run clears everything
        step(1, 1, 2'd2, 12'h008, 32'h1, "R1 pre-reset set");
        @(negedge clk);
        compare();
        rst_n = 1'b0;
        req_valid = 1'b0;
        cur_tag = "R1 reset clears";
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1 after reset");
        idle("R1 after reset");
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule